// File: doc/BRIEF.md
# Transmit Pad-Strip Realigner

This block sits on the transmit path in front of a 10G Ethernet MAC. Frames arrive on a 64-bit AXI4-Stream slave port with six filler bytes in front of the Ethernet header. The block throws those six bytes away and shifts the rest of the frame left across word boundaries, so the destination address starts at byte 0 of the first output word. Byte 0 of a word sits in bits [63:56]. Each output word is built from the last two bytes of one input word followed by the first six bytes of the next input word.

On the master side, tuser carries a start-of-frame flag and the byte count of the last word. Both sides use full valid/ready backpressure. The output is taken from registers. A small controller with three states runs the block:
- **ST_HEAD**: waiting for the first word of a frame.
- **ST_BODY**: two tail bytes are held, waiting for the next word.
- **ST_FLUSH**: the held tail bytes still have to go out as an extra final beat.

The transitions out of the states are:
- **PRIME** (HEAD→BODY): first word, not last.
- **DROP** and **SOLO** (HEAD→HEAD): single-word frames.
- **JOIN** (BODY→BODY): a middle word.
- **JOIN_END** (BODY→HEAD): a short last word.
- **JOIN_HOLD** (BODY→FLUSH): a long last word.
- **FLUSH** (FLUSH→HEAD): the extra beat is loaded.

Top module: `txstrip_realign`

## Requirements
- R1: While reset is high and right after it, m_tvalid is 0 and s_tready is 1.
- R2: The output stream holds exactly the frame bytes from input byte index 6 onward, in order. Byte 0 of a word is at bits [63:56], and output word j is input word j's bytes 6..7 followed by input word j+1's bytes 0..5.
- R3: For a frame of two or more words whose last word has occupancy 1 to 6, the frame ends with the output word built from the previous input word. The frame gives exactly one beat fewer than its input word count.
- R4: For a frame of two or more words whose last word has occupancy 7 or 0, one extra last beat carries the remaining 1 or 2 bytes. s_tready is 0 in the cycle after that last input word is accepted.
- R5: The output occupancy in tuser[2:0] on the tlast beat equals (input occupancy − 6) mod 8, where 0 means 8 valid bytes. tuser[2:0] is 0 on every beat that is not last.
- R6: tuser[3] is 1 on the first output beat of each frame and 0 on every other beat.
- R7: Input tuser[3] has no effect on any output, and input tuser[2:0] is read only on the input tlast beat.
- R8: A one-word frame with occupancy 1 to 6 produces no output beat. A one-word frame with occupancy 7 or 0 produces a single beat with tlast=1, tuser[3]=1 and occupancy 1 or 2.
- R9: While m_tvalid is 1 and m_tready is 0, m_tdata, m_tuser and m_tlast hold their values, m_tvalid stays 1, and s_tready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | 64 | Input data, byte 0 in [63:56] |
| s_tuser | input | 4 | [3] error (ignored), [2:0] occupancy on the last word |
| s_tlast | input | 1 | Last input word of the frame |
| s_tvalid | input | 1 | Input word valid |
| s_tready | output | 1 | Input word accepted when high with s_tvalid |
| m_tdata | output | 64 | Realigned data |
| m_tuser | output | 4 | [3] start of frame, [2:0] occupancy on the last beat |
| m_tlast | output | 1 | Last output beat of the frame |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts the beat |

## Verification
The bench builds the block with its default 8-byte lanes and 6-byte strip. At that size, every frame length from one to five words crosses every last-word occupancy from 0 to 7. This covers the drop, single, short-end and flush paths. Each combination runs under three downstream ready patterns (always, alternate-ish, mostly) and with and without input valid gaps. This exposes the block to stalls in every state, including the flush beat.

// File: rtl/txstrip_pkg.sv
package txstrip_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_HEAD  = 2'd0,
        ST_BODY  = 2'd1,
        ST_FLUSH = 2'd2
    } strip_state_e;

    // Datapath actions chosen by the controller each cycle
    typedef enum logic [2:0] {
        ACT_IDLE      = 3'd0,
        ACT_PRIME     = 3'd1,  // first word: keep tail only
        ACT_DROP      = 3'd2,  // one-word frame, nothing left after strip
        ACT_SOLO      = 3'd3,  // one-word frame, tail becomes whole frame
        ACT_JOIN      = 3'd4,  // tail + head, frame continues
        ACT_JOIN_END  = 3'd5,  // tail + head, frame ends here
        ACT_JOIN_HOLD = 3'd6,  // tail + head, remaining tail needs flush
        ACT_FLUSH     = 3'd7   // emit held tail as final beat
    } strip_act_e;

endpackage

// File: rtl/txstrip_ctrl.sv
module txstrip_ctrl
    import txstrip_pkg::*;
#(
    parameter  int LANES = 8,
    parameter  int STRIP = 6,
    localparam int OCC_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [OCC_W-1:0] in_occ,
    input  logic             out_free,
    output logic             in_ready,
    output strip_act_e       act,
    output logic             sof_mark
);

    localparam logic [OCC_W-1:0] STRIP_OCC = OCC_W'(STRIP);

    strip_state_e state_q;
    strip_state_e state_d;
    logic         sof_pend_q;
    logic         short_tail;
    logic         take;

    // last word holds no more bytes than are stripped
    assign short_tail = (in_occ != '0) && (in_occ <= STRIP_OCC);
    assign in_ready   = out_free && (state_q != ST_FLUSH);
    assign take       = in_valid && in_ready;
    assign sof_mark   = (act == ACT_SOLO) || sof_pend_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_HEAD;
            sof_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (act == ACT_PRIME) begin
                sof_pend_q <= 1'b1;
            end else if (act == ACT_JOIN || act == ACT_JOIN_END || act == ACT_JOIN_HOLD) begin
                sof_pend_q <= 1'b0;
            end
        end
    end

    // next state and action
    always_comb begin
        state_d = state_q;
        act     = ACT_IDLE;
        unique case (state_q)
            ST_HEAD: begin
                if (take) begin
                    if (!in_last) begin
                        act     = ACT_PRIME;
                        state_d = ST_BODY;
                    end else if (short_tail) begin
                        act = ACT_DROP;
                    end else begin
                        act = ACT_SOLO;
                    end
                end
            end
            ST_BODY: begin
                if (take) begin
                    if (!in_last) begin
                        act = ACT_JOIN;
                    end else if (short_tail) begin
                        act     = ACT_JOIN_END;
                        state_d = ST_HEAD;
                    end else begin
                        act     = ACT_JOIN_HOLD;
                        state_d = ST_FLUSH;
                    end
                end
            end
            ST_FLUSH: begin
                if (out_free) begin
                    act     = ACT_FLUSH;
                    state_d = ST_HEAD;
                end
            end
            default: begin
                state_d = ST_HEAD;
            end
        endcase
    end

endmodule

// File: rtl/txstrip_lane.sv
module txstrip_lane
    import txstrip_pkg::*;
#(
    parameter  int LANES = 8,
    parameter  int STRIP = 6,
    localparam int OCC_W = $clog2(LANES),
    localparam int DW    = LANES * 8
) (
    input  logic             clk,
    input  logic             rst,
    input  strip_act_e       act,
    input  logic             sof_mark,
    input  logic [DW-1:0]    in_data,
    input  logic [OCC_W-1:0] in_occ,
    input  logic             out_ready,
    output logic [DW-1:0]    out_data,
    output logic [OCC_W:0]   out_user,
    output logic             out_last,
    output logic             out_valid,
    output logic             out_free
);

    localparam int KEEP_W = (LANES - STRIP) * 8;
    localparam int HEAD_W = STRIP * 8;
    localparam logic [OCC_W-1:0] STRIP_OCC = OCC_W'(STRIP);

    logic [KEEP_W-1:0] tail_q;
    logic [OCC_W-1:0]  flush_occ_q;
    logic [DW-1:0]     data_q;
    logic [OCC_W-1:0]  occ_q;
    logic              sof_q;
    logic              last_q;
    logic              valid_q;

    logic [OCC_W-1:0]  occ_adj;
    logic [DW-1:0]     joined;
    logic [DW-1:0]     lone;

    assign occ_adj  = in_occ - STRIP_OCC;
    assign joined   = {tail_q, in_data[DW-1 -: HEAD_W]};
    assign lone     = {in_data[KEEP_W-1:0], {HEAD_W{1'b0}}};
    assign out_free = !valid_q || out_ready;

    assign out_data  = data_q;
    assign out_user  = {sof_q, occ_q};
    assign out_last  = last_q;
    assign out_valid = valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_q      <= '0;
            flush_occ_q <= '0;
            data_q      <= '0;
            occ_q       <= '0;
            sof_q       <= 1'b0;
            last_q      <= 1'b0;
            valid_q     <= 1'b0;
        end else begin
            if (out_ready) begin
                valid_q <= 1'b0;
            end
            unique case (act)
                ACT_PRIME: begin
                    tail_q <= in_data[KEEP_W-1:0];
                end
                ACT_SOLO: begin
                    data_q  <= lone;
                    occ_q   <= occ_adj;
                    sof_q   <= sof_mark;
                    last_q  <= 1'b1;
                    valid_q <= 1'b1;
                end
                ACT_JOIN: begin
                    data_q  <= joined;
                    occ_q   <= '0;
                    sof_q   <= sof_mark;
                    last_q  <= 1'b0;
                    valid_q <= 1'b1;
                    tail_q  <= in_data[KEEP_W-1:0];
                end
                ACT_JOIN_END: begin
                    data_q  <= joined;
                    occ_q   <= occ_adj;
                    sof_q   <= sof_mark;
                    last_q  <= 1'b1;
                    valid_q <= 1'b1;
                end
                ACT_JOIN_HOLD: begin
                    data_q      <= joined;
                    occ_q       <= '0;
                    sof_q       <= sof_mark;
                    last_q      <= 1'b0;
                    valid_q     <= 1'b1;
                    tail_q      <= in_data[KEEP_W-1:0];
                    flush_occ_q <= occ_adj;
                end
                ACT_FLUSH: begin
                    data_q  <= {tail_q, {HEAD_W{1'b0}}};
                    occ_q   <= flush_occ_q;
                    sof_q   <= 1'b0;
                    last_q  <= 1'b1;
                    valid_q <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/txstrip_realign.sv
module txstrip_realign
    import txstrip_pkg::*;
#(
    parameter  int LANES = 8,
    parameter  int STRIP = 6,
    localparam int OCC_W = $clog2(LANES),
    localparam int DW    = LANES * 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [DW-1:0]  s_tdata,
    input  logic [OCC_W:0] s_tuser,
    input  logic           s_tlast,
    input  logic           s_tvalid,
    output logic           s_tready,
    output logic [DW-1:0]  m_tdata,
    output logic [OCC_W:0] m_tuser,
    output logic           m_tlast,
    output logic           m_tvalid,
    input  logic           m_tready
);

    if (STRIP < 1 || STRIP >= LANES || (1 << OCC_W) != LANES) begin : g_bad_cfg
        $error("txstrip_realign: STRIP must be 1..LANES-1 and LANES a power of two");
    end

    strip_act_e act;
    logic       sof_mark;
    logic       out_free;
    logic       unused_err;

    // error flag travels no further
    assign unused_err = s_tuser[OCC_W];

    txstrip_ctrl #(
        .LANES (LANES),
        .STRIP (STRIP)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (s_tvalid),
        .in_last  (s_tlast),
        .in_occ   (s_tuser[OCC_W-1:0]),
        .out_free (out_free),
        .in_ready (s_tready),
        .act      (act),
        .sof_mark (sof_mark)
    );

    txstrip_lane #(
        .LANES (LANES),
        .STRIP (STRIP)
    ) lane_i (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .sof_mark  (sof_mark),
        .in_data   (s_tdata),
        .in_occ    (s_tuser[OCC_W-1:0]),
        .out_ready (m_tready),
        .out_data  (m_tdata),
        .out_user  (m_tuser),
        .out_last  (m_tlast),
        .out_valid (m_tvalid),
        .out_free  (out_free)
    );

endmodule

// File: rtl/txstrip_realign_chk.sv
module txstrip_realign_chk #(
    parameter  int LANES = 8,
    parameter  int STRIP = 6,
    localparam int OCC_W = $clog2(LANES),
    localparam int DW    = LANES * 8
) (
    input logic           clk,
    input logic           rst,
    input logic           s_tvalid,
    input logic           s_tready,
    input logic           s_tlast,
    input logic [OCC_W-1:0] s_occ,
    input logic [DW-1:0]  m_tdata,
    input logic [OCC_W:0] m_tuser,
    input logic           m_tlast,
    input logic           m_tvalid,
    input logic           m_tready
);

    localparam logic [OCC_W-1:0] STRIP_OCC = OCC_W'(STRIP);

    logic out_mid_q;  // an output frame has started and not ended
    logic in_mid_q;   // an input frame has started and not ended
    logic long_tail;

    assign long_tail = (s_occ == '0) || (s_occ > STRIP_OCC);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_mid_q <= 1'b0;
            in_mid_q  <= 1'b0;
        end else begin
            if (m_tvalid && m_tready) out_mid_q <= !m_tlast;
            if (s_tvalid && s_tready) in_mid_q  <= !s_tlast;
        end
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !m_tvalid && s_tready);

    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast));

    a_r9_input_stalled: assert property (@(posedge clk) disable iff (rst)
        m_tvalid && !m_tready |-> !s_tready);

    a_r5_mid_occ_zero: assert property (@(posedge clk) disable iff (rst)
        m_tvalid && !m_tlast |-> m_tuser[OCC_W-1:0] == '0);

    a_r6_sof_on_first: assert property (@(posedge clk) disable iff (rst)
        m_tvalid && !out_mid_q |-> m_tuser[OCC_W]);

    a_r6_no_sof_later: assert property (@(posedge clk) disable iff (rst)
        m_tvalid && out_mid_q |-> !m_tuser[OCC_W]);

    a_r4_flush_blocks_input: assert property (@(posedge clk) disable iff (rst)
        s_tvalid && s_tready && s_tlast && in_mid_q && long_tail |=> !s_tready);

endmodule

bind txstrip_realign txstrip_realign_chk #(
    .LANES (LANES),
    .STRIP (STRIP)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .s_tlast  (s_tlast),
    .s_occ    (s_tuser[OCC_W-1:0]),
    .m_tdata  (m_tdata),
    .m_tuser  (m_tuser),
    .m_tlast  (m_tlast),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready)
);

// File: tb/txstrip_realign_tb_top.sv
module txstrip_realign_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 8;
    localparam int STRIP      = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] s_tdata = '0;
    logic [3:0]  s_tuser = '0;
    logic        s_tlast = 1'b0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [63:0] m_tdata;
    logic [3:0]  m_tuser;
    logic        m_tlast;
    logic        m_tvalid;
    logic        m_tready = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit done = 0;

    logic [63:0] q_data[$];
    int          q_cnt[$];
    bit          q_last[$];
    bit          q_sof[$];
    logic [2:0]  q_occ[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    txstrip_realign #(.LANES(LANES), .STRIP(STRIP)) dut_i (
        .clk(clk), .rst(rst),
        .s_tdata(s_tdata), .s_tuser(s_tuser), .s_tlast(s_tlast),
        .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pay(input int f, input int i);
        return 8'((f * 37 + i * 5 + 1) & 255);
    endfunction

    // downstream ready patterns
    always @(posedge clk) begin
        #1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: m_tready <= 1'b1;
            1: m_tready <= lfsr[0];
            default: m_tready <= (lfsr[2:1] != 2'b00);
        endcase
    end

    // output monitor
    logic        stall_prev = 1'b0;
    logic [63:0] data_prev = '0;
    logic [3:0]  user_prev = '0;
    logic        last_prev = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (stall_prev) begin
                chk(m_tvalid, "R9", "valid dropped in stall", 64'(m_tvalid), 64'd1);
                chk(m_tdata == data_prev && m_tuser == user_prev && m_tlast == last_prev,
                    "R9", "output changed in stall", m_tdata, data_prev);
            end
            if (m_tvalid && !m_tready) begin
                chk(!s_tready, "R9", "input not stalled", 64'(s_tready), 64'd0);
            end
            stall_prev = m_tvalid && !m_tready;
            data_prev  = m_tdata;
            user_prev  = m_tuser;
            last_prev  = m_tlast;
            if (m_tvalid && m_tready) begin
                if (q_data.size() == 0) begin
                    chk(1'b0, "R8", "unexpected beat", m_tdata, 64'd0);
                end else begin
                    logic [63:0] ed, mask;
                    int cnt;
                    bit el, es;
                    logic [2:0] eo;
                    string tg;
                    ed = q_data.pop_front(); cnt = q_cnt.pop_front();
                    el = q_last.pop_front(); es = q_sof.pop_front();
                    eo = q_occ.pop_front(); tg = q_tag.pop_front();
                    mask = ~64'd0 << (64 - 8 * cnt);
                    chk((m_tdata & mask) == (ed & mask), "R2 R7", "data", m_tdata & mask, ed & mask);
                    chk(m_tuser[3] == es, "R6", "sof", 64'(m_tuser[3]), 64'(es));
                    chk(m_tlast == el, tg, "tlast", 64'(m_tlast), 64'(el));
                    chk(m_tuser[2:0] == eo, "R5", "occupancy", 64'(m_tuser[2:0]), 64'(eo));
                end
            end
        end
    end

    task automatic send_frame(input int f, input int k, input int occ, input bit gaps);
        int n, tot, m;
        string tg;
        n   = (occ == 0) ? 8 : occ;
        tot = 8 * (k - 1) + n;
        m   = tot - STRIP;
        tg  = (k == 1) ? "R8" : ((n <= STRIP) ? "R3" : "R4");
        for (int p = 0; p < m; p += 8) begin
            logic [63:0] d;
            int c;
            d = '0;
            for (int j = 0; j < 8; j++) begin
                if (STRIP + p + j < tot) d[63 - 8 * j -: 8] = pay(f, STRIP + p + j);
            end
            c = (m - p < 8) ? (m - p) : 8;
            q_data.push_back(d);
            q_cnt.push_back(c);
            q_last.push_back(p + 8 >= m);
            q_sof.push_back(p == 0);
            q_occ.push_back((p + 8 >= m) ? 3'(c % 8) : 3'd0);
            q_tag.push_back(tg);
        end
        for (int w = 0; w < k; w++) begin
            logic [63:0] d;
            bit ok;
            if (gaps && (w % 2 == 1)) begin
                s_tvalid = 1'b0;
                @(posedge clk); #1;
            end
            for (int j = 0; j < 8; j++) begin
                d[63 - 8 * j -: 8] = (w * 8 + j < tot) ? pay(f, w * 8 + j) : 8'hEE;
            end
            s_tdata  = d;
            s_tlast  = (w == k - 1);
            s_tuser  = {1'((f + w) & 1), (w == k - 1) ? 3'(occ) : 3'(f + w)};
            s_tvalid = 1'b1;
            ok = 0;
            while (!ok) begin
                @(negedge clk); ok = s_tready;
                @(posedge clk); #1;
            end
        end
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    initial begin
        int f;
        f = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!m_tvalid, "R1", "valid in reset", 64'(m_tvalid), 64'd0);
        chk(s_tready, "R1", "ready in reset", 64'(s_tready), 64'd1);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk(!m_tvalid, "R1", "valid after reset", 64'(m_tvalid), 64'd0);
        chk(s_tready, "R1", "ready after reset", 64'(s_tready), 64'd1);
        @(posedge clk); #1;
        for (int md = 0; md < 3; md++) begin
            rdy_mode = md;
            for (int g = 0; g < 2; g++) begin
                for (int k = 1; k <= 5; k++) begin
                    for (int oc = 0; oc < 8; oc++) begin
                        send_frame(f, k, oc, g[0]);
                        f++;
                    end
                end
            end
        end
        rdy_mode = 0;
        for (int t = 0; t < 200 && q_data.size() != 0; t++) @(posedge clk);
        repeat (3) @(posedge clk);
        chk(q_data.size() == 0, "R3 R4", "beats missing", 64'(q_data.size()), 64'd0);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R9 actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule